// File: doc/BRIEF.md
# Clock Chip Power-Up Validity Sequencer

This block runs once after reset. It steps a serial register master through the power-up check of an external real-time clock chip. Chip enable starts low and is raised before the first register access. The block then reads the chip's control register and looks at the oscillator-stopped bit. When that bit is clear, the stored time is trusted: the valid flag rises and the sequence ends.

When the bit is set, the time is not trusted and the block runs a recovery path:
- it writes zero to the timer-interrupt register;
- it writes the control register with the base value plus the adjust bit;
- it polls the control register's busy bit, with a fixed delay of about one microsecond between polls, up to a bounded number of reads;
- if busy clears, it writes the base value back alone;
- if every allowed poll sees busy, it raises the error flag.

Both endings drop chip enable and give a one-cycle done pulse. The flags then keep their values until the next reset.

The block does not shift bits itself. It asks a register master for one whole register access at a time, with a request/acknowledge pair. The register addresses, the base control value, the bit masks, the retry limit and the delay (given in nanoseconds together with the clock frequency) are parameters.

Top module: `rtc_validity_seq`

## Requirements
- R1: During reset `ceOut`, `regReq`, `seqDone`, `timeValid` and `ioError` are all 0. After reset is released, `ceOut` is high for exactly one cycle with no request before the first access begins.
- R2: The first access is a read (`regWrite`=0) of `CTRL_ADDR` (default 0xF). If the bit `STOP_MASK` (default 0x8) of the returned data is 0, `timeValid` becomes 1 and no further access is made.
- R3: If the stop bit is 1, `timeValid` stays 0. The next access is a write of 0 to `TINT_ADDR` (default 0xE). That is followed by a write of `BASE_VAL | ADJ_MASK` (default 0x4 | 0x1 = 0x5) to `CTRL_ADDR`.
- R4: After the adjust write, the block reads `CTRL_ADDR` repeatedly until bit `BUSY_MASK` (default 0x2) reads 0, making at most `MAX_POLLS` (default 1000) such reads. The stop bit in these poll results has no effect.
- R5: After a poll that returns busy, `regReq` stays low for exactly DELAY_CYC = CLK_HZ/1000 × DELAY_NS / 1,000,000 cycles (default 50) before the next poll. All other accesses follow their predecessor with no idle cycle.
- R6: If all `MAX_POLLS` polls return busy, `ioError` becomes 1, `timeValid` stays 0 and no further access is made.
- R7: When a poll returns busy clear, the next and last access writes `BASE_VAL` (0x4) to `CTRL_ADDR`, and `ioError` stays 0. This holds even when busy clears on the final allowed poll.
- R8: At the end of either path, `seqDone` is high for exactly one cycle, with `ceOut` low. Afterwards `ceOut` and `regReq` stay low, and the flags hold their values until reset.
- R9: Once raised, `regReq` stays high, with `regWrite`, `regAddr` and `regWData` stable, up to and including the cycle in which `regAck` is high. `ceOut` is high in every cycle that `regReq` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; starts the sequence when released |
| regAck | input | 1 | One-cycle completion strobe from the register master |
| regRData | input | DATA_W | Read data from the register master, valid with `regAck` |
| ceOut | output | 1 | Chip enable for the clock chip |
| regReq | output | 1 | Register access request, held until acknowledged |
| regWrite | output | 1 | 1 = write access, 0 = read access |
| regAddr | output | ADDR_W | Register address of the access |
| regWData | output | DATA_W | Write data of the access |
| timeValid | output | 1 | The chip's stored time is trusted |
| ioError | output | 1 | Busy never cleared within the retry limit |
| seqDone | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
Two events can land in the same cycle: the poll counter reaching its limit, and a poll result showing busy clear. In that cycle the block must take the success path. The bench provokes this by answering 999 polls with busy and the 1000th with busy clear. It judges the result by expecting the base write, `ioError` low and exactly 1000 poll reads. A neighbouring run keeps busy set forever and must give the error ending, with no base write.

// File: rtl/rtc_validity_pkg.sv
package rtc_validity_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_CTRL,
    ACC_WR_TINT,
    ACC_WR_ADJ,
    ACC_WR_BASE
  } acc_e;

  typedef enum logic [3:0] {
    S_OFF,
    S_CE,
    S_CHECK,
    S_CLR_TINT,
    S_ADJ,
    S_POLL,
    S_WAIT,
    S_BASE,
    S_END,
    S_HALT
  } state_e;

  typedef struct packed {
    acc_e acc;
    logic clrPoll;
    logic incPoll;
    logic clrDelay;
    logic incDelay;
    logic setValid;
    logic setErr;
  } seq_strobe_t;

endpackage

// File: rtl/rtc_validity_ctrl.sv
module rtc_validity_ctrl
  import rtc_validity_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regAck,
  input  logic        stopHit,
  input  logic        busyHit,
  input  logic        pollLast,
  input  logic        delayDone,
  output seq_strobe_t strb,
  output logic        ceOut,
  output logic        seqDone
);

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    strb.acc  = ACC_NONE;
    nextState = state;
    case (state)
      S_OFF: nextState = S_CE;
      S_CE:  nextState = S_CHECK;
      S_CHECK: begin
        strb.acc = ACC_RD_CTRL;
        if (regAck) begin
          if (stopHit) nextState = S_CLR_TINT;
          else begin
            strb.setValid = 1'b1;
            nextState     = S_END;
          end
        end
      end
      S_CLR_TINT: begin
        strb.acc = ACC_WR_TINT;
        if (regAck) nextState = S_ADJ;
      end
      S_ADJ: begin
        strb.acc = ACC_WR_ADJ;
        if (regAck) begin
          strb.clrPoll = 1'b1;
          nextState    = S_POLL;
        end
      end
      S_POLL: begin
        strb.acc = ACC_RD_CTRL;
        if (regAck) begin
          if (!busyHit) nextState = S_BASE;
          else if (pollLast) begin
            strb.setErr = 1'b1;
            nextState   = S_END;
          end else begin
            strb.incPoll  = 1'b1;
            strb.clrDelay = 1'b1;
            nextState     = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        strb.incDelay = 1'b1;
        if (delayDone) nextState = S_POLL;
      end
      S_BASE: begin
        strb.acc = ACC_WR_BASE;
        if (regAck) nextState = S_END;
      end
      S_END:   nextState = S_HALT;
      default: nextState = S_HALT;
    endcase
  end

  assign ceOut   = !(state == S_OFF || state == S_END || state == S_HALT);
  assign seqDone = (state == S_END);

endmodule

// File: rtl/rtc_validity_dpath.sv
module rtc_validity_dpath
  import rtc_validity_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter int              DATA_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] TINT_ADDR = 4'hE,
  parameter logic [DATA_W-1:0] BASE_VAL  = 4'h4,
  parameter logic [DATA_W-1:0] ADJ_MASK  = 4'h1,
  parameter logic [DATA_W-1:0] BUSY_MASK = 4'h2,
  parameter logic [DATA_W-1:0] STOP_MASK = 4'h8,
  parameter int              MAX_POLLS = 1000,
  parameter int              DELAY_CYC = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [DATA_W-1:0] regRData,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWData,
  output logic              stopHit,
  output logic              busyHit,
  output logic              pollLast,
  output logic              delayDone,
  output logic              timeValid,
  output logic              ioError
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int DLY_W  = $clog2(DELAY_CYC + 1);

  logic [POLL_W-1:0] pollCnt;
  logic [DLY_W-1:0]  delayCnt;
  logic              validQ, errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt  <= '0;
      delayCnt <= '0;
      validQ   <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (strb.clrPoll)       pollCnt  <= '0;
      else if (strb.incPoll)  pollCnt  <= pollCnt + 1'b1;
      if (strb.clrDelay)      delayCnt <= '0;
      else if (strb.incDelay) delayCnt <= delayCnt + 1'b1;
      if (strb.setValid)      validQ   <= 1'b1;
      if (strb.setErr)        errQ     <= 1'b1;
    end
  end

  always_comb begin
    regReq   = 1'b1;
    regWrite = 1'b1;
    regAddr  = CTRL_ADDR;
    regWData = '0;
    case (strb.acc)
      ACC_RD_CTRL: regWrite = 1'b0;
      ACC_WR_TINT: regAddr  = TINT_ADDR;
      ACC_WR_ADJ:  regWData = BASE_VAL | ADJ_MASK;
      ACC_WR_BASE: regWData = BASE_VAL;
      default: begin
        regReq   = 1'b0;
        regWrite = 1'b0;
      end
    endcase
  end

  assign stopHit   = |(regRData & STOP_MASK);
  assign busyHit   = |(regRData & BUSY_MASK);
  assign pollLast  = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign delayDone = (delayCnt == DLY_W'(DELAY_CYC - 1));
  assign timeValid = validQ;
  assign ioError   = errQ;

endmodule

// File: rtl/rtc_validity_seq.sv
module rtc_validity_seq
  import rtc_validity_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter int              DATA_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] TINT_ADDR = 4'hE,
  parameter logic [DATA_W-1:0] BASE_VAL  = 4'h4,
  parameter logic [DATA_W-1:0] ADJ_MASK  = 4'h1,
  parameter logic [DATA_W-1:0] BUSY_MASK = 4'h2,
  parameter logic [DATA_W-1:0] STOP_MASK = 4'h8,
  parameter int              MAX_POLLS = 1000,
  parameter int              CLK_HZ    = 50_000_000,
  parameter int              DELAY_NS  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRData,
  output logic              ceOut,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWData,
  output logic              timeValid,
  output logic              ioError,
  output logic              seqDone
);

  localparam int DELAY_RAW = (CLK_HZ / 1000) * DELAY_NS / 1_000_000;
  localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

  seq_strobe_t strb;
  logic stopHit, busyHit, pollLast, delayDone;

  rtc_validity_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAck(regAck),
    .stopHit(stopHit), .busyHit(busyHit), .pollLast(pollLast), .delayDone(delayDone),
    .strb(strb), .ceOut(ceOut), .seqDone(seqDone)
  );

  rtc_validity_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .TINT_ADDR(TINT_ADDR),
    .BASE_VAL(BASE_VAL), .ADJ_MASK(ADJ_MASK), .BUSY_MASK(BUSY_MASK), .STOP_MASK(STOP_MASK),
    .MAX_POLLS(MAX_POLLS), .DELAY_CYC(DELAY_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regRData(regRData),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWData(regWData),
    .stopHit(stopHit), .busyHit(busyHit), .pollLast(pollLast), .delayDone(delayDone),
    .timeValid(timeValid), .ioError(ioError)
  );

endmodule

// File: rtl/rtc_validity_chk.sv
module rtc_validity_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceOut,
  input logic              regReq,
  input logic              regAck,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWData,
  input logic              timeValid,
  input logic              ioError,
  input logic              seqDone
);

  logic finished;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        finished <= 1'b0;
    else if (seqDone) finished <= 1'b1;
  end

  AST_CE_COVERS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> ceOut); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regWrite) && $stable(regAddr) && $stable(regWData))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone); // R8

  AST_DONE_CE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!ceOut && !regReq)); // R8

  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> (!ceOut && !regReq && !seqDone)); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    finished |=> ($stable(timeValid) && $stable(ioError))); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(timeValid && ioError)); // R6

endmodule

bind rtc_validity_seq rtc_validity_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceOut(ceOut), .regReq(regReq), .regAck(regAck),
  .regWrite(regWrite), .regAddr(regAddr), .regWData(regWData),
  .timeValid(timeValid), .ioError(ioError), .seqDone(seqDone)
);

// File: tb/rtc_validity_seq_test.sv
`timescale 1ns/1ps
module rtc_validity_seq_test;

  localparam int LAT       = 2;
  localparam int DELAY_CYC = 50;
  localparam int MAXP      = 1000;
  localparam int E_CTRL    = 15;
  localparam int E_TINT    = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regAck = 1'b0;
  logic [3:0] regRData = 4'h0;
  logic       ceOut, regReq, regWrite, timeValid, ioError, seqDone;
  logic [3:0] regAddr, regWData;

  int total = 0;
  int failed = 0;
  int cycles = 0;

  // register master model and per-clock observations
  bit stopSet;
  int busyPolls;
  int reqCnt, gapCnt, ctrlReads, ceOnlyCycles;
  bit seenReq, doneSeen;
  int doneCnt, violCe, violDoneCe, violAfter;
  int txnQ[$];
  int gapQ[$];

  rtc_validity_seq uut (
    .clk(clk), .rstN(rstN), .regAck(regAck), .regRData(regRData),
    .ceOut(ceOut), .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr),
    .regWData(regWData), .timeValid(timeValid), .ioError(ioError), .seqDone(seqDone)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycles++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      regAck = 1'b0;
      reqCnt = 0;
      gapCnt = 0;
    end else begin
      if (regAck) regAck = 1'b0;
      if (regReq && !ceOut) violCe++;
      if (!seenReq && ceOut && !regReq) ceOnlyCycles++;
      if (doneSeen && (regReq || ceOut)) violAfter++;
      if (seqDone) begin
        doneCnt++;
        if (ceOut) violDoneCe++;
        doneSeen = 1'b1;
      end
      if (regReq) begin
        if (reqCnt == 0) begin
          if (seenReq) gapQ.push_back(gapCnt);
          gapCnt  = 0;
          seenReq = 1'b1;
        end
        reqCnt++;
        if (reqCnt == LAT + 1) begin
          txnQ.push_back(regWrite * 256 + regAddr * 16 + regWData);
          if (!regWrite) begin
            if (ctrlReads == 0) regRData = stopSet ? 4'h8 : 4'h0;
            else regRData = ((ctrlReads - 1) < busyPolls) ? 4'hA : 4'h8;
            ctrlReads++;
          end
          regAck = 1'b1;
          reqCnt = 0;
        end
      end else if (seenReq) begin
        gapCnt++;
      end
    end
  end

  task automatic runCase(input string name, input bit stop, input int busyN);
    int expT[$];
    int expG[$];
    int polls;
    bit txOk, gapOk;
    stopSet = stop;
    busyPolls = busyN;
    txnQ.delete();
    gapQ.delete();
    ctrlReads = 0; ceOnlyCycles = 0; seenReq = 0; doneSeen = 0;
    doneCnt = 0; violCe = 0; violDoneCe = 0; violAfter = 0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({"R1 reset ce ", name}, ceOut, 0);
    check({"R1 reset outputs ", name}, {regReq, seqDone, timeValid, ioError}, 0);
    rstN = 1'b1;
    while (doneCnt == 0) @(negedge clk);
    repeat (10) @(negedge clk);

    expT.push_back(E_CTRL * 16);
    if (stop) begin
      expT.push_back(256 + E_TINT * 16);
      expT.push_back(256 + E_CTRL * 16 + 5);
      expG.push_back(0);
      expG.push_back(0);
      polls = (busyN < MAXP) ? busyN + 1 : MAXP;
      for (int i = 0; i < polls; i++) begin
        expT.push_back(E_CTRL * 16);
        expG.push_back(i == 0 ? 0 : DELAY_CYC);
      end
      if (busyN < MAXP) begin
        expT.push_back(256 + E_CTRL * 16 + 4);
        expG.push_back(0);
      end
    end

    check({"R1 ce lead cycles ", name}, ceOnlyCycles, 1);
    txOk = (txnQ.size() == expT.size());
    for (int i = 0; i < expT.size() && txOk; i++)
      if (txnQ[i] != expT[i]) begin
        txOk = 0;
        $display("FAIL R3 access %0d of %s actual=%0h expected=%0h", i, name, txnQ[i], expT[i]);
      end
    if (!stop) check({"R2 access list ", name}, txOk, 1);
    else if (busyN >= MAXP) check({"R4 R6 access list ", name}, txOk, 1);
    else check({"R3 R4 R7 access list ", name}, txOk, 1);
    check({"R4 access count ", name}, txnQ.size(), expT.size());
    gapOk = (gapQ.size() == expG.size());
    for (int i = 0; i < expG.size() && gapOk; i++)
      if (gapQ[i] != expG[i]) gapOk = 0;
    check({"R5 idle gaps ", name}, gapOk, 1);
    check({"R2 R3 timeValid ", name}, timeValid, stop ? 0 : 1);
    check({"R6 R7 ioError ", name}, ioError, (stop && busyN >= MAXP) ? 1 : 0);
    check({"R8 done pulses ", name}, doneCnt, 1);
    check({"R8 ce at done ", name}, violDoneCe, 0);
    check({"R8 quiet after ", name}, violAfter, 0);
    check({"R9 ce under req ", name}, violCe, 0);
  endtask

  initial begin
    runCase("stop_clear", 0, 0);
    runCase("busy_none", 1, 0);
    runCase("busy_three", 1, 3);
    runCase("busy_last_poll", 1, MAXP - 1);
    runCase("busy_forever", 1, 2 * MAXP);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    total++;
    failed++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule